// File: doc/BRIEF.md
# Serial CRC Engine for an SPI Port

This block computes a running CRC on the bit stream of an SPI shifter, one bit for each bit-valid strobe. A small control word turns updating on and off, clears the CRC to all ones, chooses the input stream and chooses the polynomial width. In full duplex a select bit picks the receive or the transmit line. In half duplex the shifter's direction input makes that choice. Software can read and write the 16-bit CRC value at any time. Two live flags report whether the value is all zeros or all ones.

The engine has two modes. The 16-bit mode uses x^16+x^12+x^5+1. The 7-bit mode uses x^7+x^3+1 on the low seven bits. In both modes bits enter most significant bit first. Control-word fields take effect in the cycle after they are written. Register priority in one cycle is: clear, then a value write, then a serial update.

Top module: `spi_crc_unit`

## Requirements
- R1: When the enable field (control bit 0) is 0, bit strobes leave the CRC value unchanged.
- R2: Writing the control word with bit 1 set loads all ones into the CRC register at that clock edge.
- R3: Control bit 1 always reads back as 0, and writing it as 0 does nothing.
- R4: With fullDuplex high, the CRC input is rxBit when control bit 2 is 1 and txBit when it is 0.
- R5: With fullDuplex low, control bit 2 is ignored. The input is rxBit when dirRx is 1 and txBit when dirRx is 0.
- R6: flagNotZero (also control read bit 4) is 0 exactly when the visible CRC value is all zeros.
- R7: flagNotOnes (also control read bit 5) is 0 exactly when the visible CRC value is all ones.
- R8: With control bit 3 set (7-bit mode), each enabled strobe shifts bits [6:0] with polynomial x^7+x^3+1, and the value reads with bits [15:7] as 0.
- R9: After reset the value reads 0xFFFF and the control word reads 0x10 (enable 0, receive select 0, 16-bit mode).
- R10: In 16-bit mode each enabled strobe shifts the value with polynomial 0x1021, feedback = bit 15 XOR input.
- R11: A value write overrides a serial update in the same cycle, and a clear overrides both.
- R12: Control bits 7:6 are reserved. Writes to them have no effect, and they read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWdata | input | 8 | Control word write data |
| ctrlRdata | output | 8 | Control word readback with status flags |
| valWe | input | 1 | CRC value write strobe |
| valWdata | input | 16 | CRC value write data |
| valRdata | output | 16 | Visible CRC value (masked in 7-bit mode) |
| bitStrobe | input | 1 | One SPI bit is valid this cycle |
| rxBit | input | 1 | Receive stream bit |
| txBit | input | 1 | Transmit stream bit |
| fullDuplex | input | 1 | Shifter runs in full duplex |
| dirRx | input | 1 | Half-duplex direction, 1 = receiving |
| flagNotZero | output | 1 | Value is not all zeros |
| flagNotOnes | output | 1 | Value is not all ones |

## Verification
The bench builds the block with its default parameters: a 16-bit register, a 7-bit short mode and the two standard polynomials. At these values both polynomial paths, the masking of the upper nine bits and the switch between modes while stale upper bits stay in storage can all be reached. Long random runs with rare control and value writes produce enough strobes to catch any feedback-tap error. Directed cases set the value to exactly zero, to all ones and to 0x0080, which in 7-bit mode reads as zero.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  // control word field positions (read and write)
  localparam int unsigned CtlEnBit    = 0;
  localparam int unsigned CtlClrBit   = 1;
  localparam int unsigned CtlRxSelBit = 2;
  localparam int unsigned CtlShortBit = 3;
  localparam int unsigned CtlNzBit    = 4;
  localparam int unsigned CtlNoBit    = 5;
  localparam int unsigned CtlUsedBits = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic clearStb;
    logic loadStb;
    logic shiftStb;
    logic shiftBit;
    logic shortMode;
  } crcStrobes_t;
endpackage

// File: rtl/spi_crc_ctrl.sv
module spi_crc_ctrl
  import spi_crc_pkg::*;
#(
  parameter int unsigned CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              valWe,
  input  logic              bitStrobe,
  input  logic              rxBit,
  input  logic              txBit,
  input  logic              fullDuplex,
  input  logic              dirRx,
  input  logic              flagNotZero,
  input  logic              flagNotOnes,
  output logic [CTRL_W-1:0] ctrlRdata,
  output crcStrobes_t       strobes
);
  localparam int unsigned RsvW = CTRL_W - CtlUsedBits;

  logic enReg, rxSelReg, shortReg;
  logic inBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      rxSelReg <= 1'b0;
      shortReg <= 1'b0;
    end else if (ctrlWe) begin
      enReg    <= ctrlWdata[CtlEnBit];
      rxSelReg <= ctrlWdata[CtlRxSelBit];
      shortReg <= ctrlWdata[CtlShortBit];
    end
  end

  // stream choice: software select in full duplex, shifter direction otherwise
  always_comb begin
    if (fullDuplex) inBit = rxSelReg ? rxBit : txBit;
    else            inBit = dirRx ? rxBit : txBit;
  end

  always_comb begin
    strobes.clearStb  = ctrlWe && ctrlWdata[CtlClrBit];
    strobes.loadStb   = valWe;
    strobes.shiftStb  = enReg && bitStrobe;
    strobes.shiftBit  = inBit;
    strobes.shortMode = shortReg;
  end

  logic [CtlUsedBits-1:0] usedRd;
  always_comb begin
    usedRd              = '0;
    usedRd[CtlEnBit]    = enReg;
    usedRd[CtlClrBit]   = 1'b0;
    usedRd[CtlRxSelBit] = rxSelReg;
    usedRd[CtlShortBit] = shortReg;
    usedRd[CtlNzBit]    = flagNotZero;
    usedRd[CtlNoBit]    = flagNotOnes;
  end

  generate
    if (RsvW > 0) begin : g_rsv
      assign ctrlRdata = {{RsvW{1'b0}}, usedRd};
    end else begin : g_norsv
      assign ctrlRdata = usedRd;
    end
  endgenerate
endmodule

// File: rtl/spi_crc_dpath.sv
module spi_crc_dpath
  import spi_crc_pkg::*;
#(
  parameter int unsigned CRC_W      = 16,
  parameter int unsigned SHORT_W    = 7,
  parameter logic [CRC_W-1:0]   POLY_LONG  = 16'h1021,
  parameter logic [SHORT_W-1:0] POLY_SHORT = 7'h09
) (
  input  logic             clk,
  input  logic             rstN,
  input  crcStrobes_t      strobes,
  input  logic [CRC_W-1:0] valWdata,
  output logic [CRC_W-1:0] valRdata,
  output logic             flagNotZero,
  output logic             flagNotOnes
);
  localparam int unsigned UpW = CRC_W - SHORT_W;
  localparam logic [CRC_W-1:0] ShortMask = {{UpW{1'b0}}, {SHORT_W{1'b1}}};

  logic [CRC_W-1:0] crcReg, crcNext, stepLong, stepShort;
  logic fbLong, fbShort;

  always_comb begin
    fbLong   = crcReg[CRC_W-1] ^ strobes.shiftBit;
    stepLong = {crcReg[CRC_W-2:0], 1'b0} ^ (fbLong ? POLY_LONG : '0);
  end

  always_comb begin
    fbShort   = crcReg[SHORT_W-1] ^ strobes.shiftBit;
    stepShort = crcReg;
    stepShort[SHORT_W-1:0] = {crcReg[SHORT_W-2:0], 1'b0} ^ (fbShort ? POLY_SHORT : '0);
  end

  always_comb begin
    if (strobes.clearStb)      crcNext = '1;
    else if (strobes.loadStb)  crcNext = valWdata;
    else if (strobes.shiftStb) crcNext = strobes.shortMode ? stepShort : stepLong;
    else                       crcNext = crcReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) crcReg <= '1;
    else       crcReg <= crcNext;
  end

  always_comb begin
    valRdata    = strobes.shortMode ? (crcReg & ShortMask) : crcReg;
    flagNotZero = |valRdata;
    flagNotOnes = strobes.shortMode ? ~&crcReg[SHORT_W-1:0] : ~&crcReg;
  end
endmodule

// File: rtl/spi_crc_unit.sv
module spi_crc_unit
  import spi_crc_pkg::*;
#(
  parameter int unsigned CRC_W   = 16,
  parameter int unsigned SHORT_W = 7,
  parameter int unsigned CTRL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [CTRL_W-1:0] ctrlRdata,
  input  logic              valWe,
  input  logic [CRC_W-1:0]  valWdata,
  output logic [CRC_W-1:0]  valRdata,
  input  logic              bitStrobe,
  input  logic              rxBit,
  input  logic              txBit,
  input  logic              fullDuplex,
  input  logic              dirRx,
  output logic              flagNotZero,
  output logic              flagNotOnes
);
  crcStrobes_t strobes;

  spi_crc_ctrl #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .valWe(valWe), .bitStrobe(bitStrobe), .rxBit(rxBit), .txBit(txBit),
    .fullDuplex(fullDuplex), .dirRx(dirRx), .flagNotZero(flagNotZero),
    .flagNotOnes(flagNotOnes), .ctrlRdata(ctrlRdata), .strobes(strobes)
  );

  spi_crc_dpath #(.CRC_W(CRC_W), .SHORT_W(SHORT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .valWdata(valWdata),
    .valRdata(valRdata), .flagNotZero(flagNotZero), .flagNotOnes(flagNotOnes)
  );
endmodule

// File: rtl/spi_crc_checker.sv
module spi_crc_checker #(
  parameter int unsigned CRC_W   = 16,
  parameter int unsigned SHORT_W = 7,
  parameter int unsigned CTRL_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWe,
  input logic [CTRL_W-1:0] ctrlWdata,
  input logic [CTRL_W-1:0] ctrlRdata,
  input logic              valWe,
  input logic [CRC_W-1:0]  valWdata,
  input logic [CRC_W-1:0]  valRdata,
  input logic              flagNotZero,
  input logic              flagNotOnes
);
  localparam logic [CRC_W-1:0] ShortMask = {{(CRC_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  assert_hold_disabled_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlRdata[0] && !ctrlWe && !valWe) |=> $stable(valRdata));

  assert_clear_ones_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && ctrlWdata[1]) |=> !flagNotOnes);

  assert_clear_reads0_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdata[1] == 1'b0);

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (valRdata == '0) |-> !flagNotZero);

  assert_upper_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdata[3] |-> ((valRdata & ~ShortMask) == '0));

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    (valWe && !ctrlWe) |=>
      (valRdata == (ctrlRdata[3] ? ($past(valWdata) & ShortMask) : $past(valWdata))));

  assert_rsv_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdata[CTRL_W-1:6] == '0);
endmodule

bind spi_crc_unit spi_crc_checker #(.CRC_W(CRC_W), .SHORT_W(SHORT_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata),
  .valWe(valWe), .valWdata(valWdata), .valRdata(valRdata),
  .flagNotZero(flagNotZero), .flagNotOnes(flagNotOnes)
);

// File: tb/tb_spi_crc_unit.sv
module tb_spi_crc_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWe = 0, valWe = 0, bitStrobe = 0, rxBit = 0, txBit = 0, fullDuplex = 0, dirRx = 0;
  logic [7:0]  ctrlWdata = 0, ctrlRdata;
  logic [15:0] valWdata = 0, valRdata;
  logic flagNotZero, flagNotOnes;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_crc_unit dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata),
    .valWe(valWe), .valWdata(valWdata), .valRdata(valRdata), .bitStrobe(bitStrobe),
    .rxBit(rxBit), .txBit(txBit), .fullDuplex(fullDuplex), .dirRx(dirRx),
    .flagNotZero(flagNotZero), .flagNotOnes(flagNotOnes)
  );

  // bench model
  logic mEn = 0, mRx = 0, mShort = 0;
  logic [15:0] mCrc = 16'hFFFF;

  function automatic logic [15:0] stepCrc(logic [15:0] c, logic b, logic sh);
    logic [15:0] r = c;
    logic fb;
    if (sh) begin
      fb = c[6] ^ b;
      r[6:0] = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    end else begin
      fb = c[15] ^ b;
      r = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return r;
  endfunction

  function automatic logic [15:0] visVal();
    return mShort ? (mCrc & 16'h007F) : mCrc;
  endfunction

  function automatic logic [7:0] expCtrl();
    logic [15:0] v = visVal();
    logic ones = mShort ? (v[6:0] == 7'h7F) : (v == 16'hFFFF);
    return {2'b00, ~ones, (v != 0), mShort, mRx, 1'b0, mEn};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic we, logic [7:0] wd, logic vwe, logic [15:0] vwd,
                     logic stb, logic rxb, logic txb, logic fd, logic dir);
    logic din;
    @(negedge clk);
    ctrlWe = we; ctrlWdata = wd; valWe = vwe; valWdata = vwd;
    bitStrobe = stb; rxBit = rxb; txBit = txb; fullDuplex = fd; dirRx = dir;
    din = fd ? (mRx ? rxb : txb) : (dir ? rxb : txb);
    if (we && wd[1])      mCrc = 16'hFFFF;
    else if (vwe)         mCrc = vwd;
    else if (mEn && stb)  mCrc = stepCrc(mCrc, din, mShort);
    if (we) begin mEn = wd[0]; mRx = wd[2]; mShort = wd[3]; end
    @(posedge clk); #1;
    ctrlWe = 0; valWe = 0; bitStrobe = 0;
  endtask

  task automatic checkAll(string tag);
    chk(tag, valRdata, visVal());
    chk(tag, ctrlRdata, expCtrl());
    chk(tag, flagNotZero, expCtrl()[4]);
    chk(tag, flagNotOnes, expCtrl()[5]);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed = 32'h5EED;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    chk("R9 reset value", valRdata, 16'hFFFF);
    chk("R9 reset ctrl", ctrlRdata, 8'h10);

    // R1: strobes without enable leave the value alone
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 1, 1, 1, 1, 0);
    chk("R1 hold disabled", valRdata, 16'hFFFF);

    // R10: 16-bit shifting with the transmit stream
    cyc(1, 8'h01, 0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 1, 0, i[0], 1, 0);
    checkAll("R10 long poly");

    // R4: full-duplex receive select
    cyc(1, 8'h05, 0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 0, 1, i[1], ~i[1], 1, 0);
    checkAll("R4 rx select");

    // R5: half duplex ignores the select and follows dirRx
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 0, 1, 1, 0, 0, i[0]);
    checkAll("R5 half duplex dir");

    // R2/R3: clear loads ones and reads back 0
    cyc(1, 8'h03, 0, 0, 0, 0, 0, 1, 0);
    chk("R2 clear ones", valRdata, 16'hFFFF);
    chk("R3 clear reads 0", ctrlRdata[1], 1'b0);
    cyc(1, 8'h01, 0, 16'h1234, 0, 0, 0, 1, 0);
    chk("R3 write 0 no effect", valRdata, 16'hFFFF);

    // R6/R7 corners
    cyc(0, 0, 1, 16'h0000, 0, 0, 0, 1, 0);
    chk("R6 zero flag", flagNotZero, 1'b0);
    chk("R7 ones flag on zero", flagNotOnes, 1'b1);
    cyc(0, 0, 1, 16'hFFFF, 0, 0, 0, 1, 0);
    chk("R7 ones flag", flagNotOnes, 1'b0);

    // R11: value write beats strobe, clear beats write
    cyc(0, 0, 1, 16'hA5A5, 1, 1, 1, 1, 0);
    chk("R11 write over shift", valRdata, 16'hA5A5);
    cyc(1, 8'h03, 1, 16'h0F0F, 1, 1, 1, 1, 0);
    chk("R11 clear over write", valRdata, 16'hFFFF);

    // R8: short mode masking and flags
    cyc(1, 8'h09, 1, 16'h0080, 0, 0, 0, 1, 0);
    chk("R8 upper masked", valRdata, 16'h0000);
    chk("R8 zero flag short", flagNotZero, 1'b0);
    cyc(0, 0, 1, 16'hFF7F, 0, 0, 0, 1, 0);
    chk("R8 ones flag short", flagNotOnes, 1'b0);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 1, 0, i[2] ^ i[0], 1, 0);
    checkAll("R8 short poly");

    // R12: reserved bits ignored and read 0
    cyc(1, 8'hC1, 0, 0, 0, 0, 0, 1, 0);
    chk("R12 reserved read 0", ctrlRdata[7:6], 2'b00);
    checkAll("R12 reserved no effect");

    // random mix checked every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      logic we  = (r[4:0] == 0);
      logic vwe = (r[9:5] == 1);
      cyc(we, {2'b00, r[15:10]}, vwe, $urandom, r[16], r[17], r[18], r[19], r[20]);
      checkAll("R10 random mix");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule